// File: doc/BRIEF.md
# Two-Drive Hard Reset Sequencer

This host-side block carries out a hard reset of a parallel disk channel that can hold one or two drives, then follows the drives as they recover. A `start` request pulls the shared active-low reset line low for a guaranteed minimum width. After release it waits a short window for drive 0 to report busy. It then watches both drives' busy status bits and two shared open-drain lines. One is the drive-active line, which the second drive pulls low to announce itself. The other is the diagnostics-passed line, which the second drive pulls low once its self-test has finished.

All long limits are counted in whole microseconds from a prescaled tick. This keeps limits of tens of seconds inside a counter of modest width. The short busy-response window is counted in clock cycles. At the end of every sequence the block gives a single-cycle `reset_done` pulse, together with an error code and a flag that tells whether the second drive was found. The code and the flag hold until the next start.

Top module: `hrst_seq`

## Requirements
- R1: With the block idle, a `start` high at a clock edge drives `rst_line_n` low and `active` high from that edge on.
- R2: `rst_line_n` stays low for at least RST_US*CLK_PER_US clock cycles and at most one cycle more.
- R3: If `drv0_busy` is not seen high within BSY_CYC cycles after `rst_line_n` rises, the sequence ends BSY_CYC to BSY_CYC+2 cycles after the rise with `err_code` = 1.
- R4: `drv_act_n` sampled low less than DET_US microseconds after the reset release sets `drv1_found`. A low on that line after the window has closed is ignored and leaves `drv1_found` at 0.
- R5: If the second drive was found and `diag_ok_n` has not gone low by DIAG_US microseconds after release, the sequence ends with `err_code` = 2, no earlier than DIAG_US*CLK_PER_US cycles after release.
- R6: If the second drive is absent, the sequence ends with `err_code` = 0 once the detection window has closed and `drv0_busy` is low. An early clear of busy does not end it before DET_US*CLK_PER_US cycles. If the second drive is present, the sequence ends with code 0 in the cycle after both busy bits are low and a diagnostics-passed low has been seen.
- R7: If the sequence has not completed by DONE_US microseconds after release, it ends with `err_code` = 3, no earlier than DONE_US*CLK_PER_US cycles after release.
- R8: Each sequence ends with `reset_done` high for exactly one cycle, in the same cycle that `active` falls. `err_code` and `drv1_found` then hold until the next start.
- R9: A `start` while `active` is high is ignored: `rst_line_n` stays high and the running sequence ends as it would have without it.
- R10: While `rst` is high and after it falls, the outputs are `rst_line_n` = 1, `active` = 0, `reset_done` = 0, `err_code` = 0 and `drv1_found` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a reset sequence |
| drv0_busy | input | 1 | Busy status bit polled from drive 0 |
| drv1_busy | input | 1 | Busy status bit polled from drive 1 |
| diag_ok_n | input | 1 | Sampled diagnostics-passed line, active low |
| drv_act_n | input | 1 | Sampled drive-active line, active low |
| rst_line_n | output | 1 | Reset line to the drives, active low |
| active | output | 1 | High while a sequence is running |
| reset_done | output | 1 | One-cycle pulse when a sequence ends |
| drv1_found | output | 1 | Second drive detected during the last sequence |
| err_code | output | 2 | 0 ok, 1 no busy response, 2 diagnostics timeout, 3 completion timeout |

## Verification
The checker assumes that `start` is a clean synchronous level. It also assumes that the busy and line inputs are already synchronized to `clk`, and that the parameters keep RST_US below DET_US, DET_US below DIAG_US and DIAG_US below DONE_US. The bench drives every input on the falling clock edge from a single per-cycle drive model. That model sets each busy bit and line as a function of the cycle count since the reset release. It uses small microsecond limits so that each timeout is reached within a few hundred cycles. A second start is issued only inside a running sequence, where it must be ignored.

// File: rtl/hrst_pkg.sv
package hrst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PULSE   = 2'd1,
        ST_WAITBSY = 2'd2,
        ST_WATCH   = 2'd3
    } hrst_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_NO_BUSY = 2'd1,
        ERR_DIAG    = 2'd2,
        ERR_LATE    = 2'd3
    } hrst_err_e;

    typedef struct packed {
        logic found;
        logic diag_seen;
    } hrst_lines_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hrst_us_timer.sv
module hrst_us_timer #(
    parameter int CLK_PER_US = 100,
    parameter int MAX_US     = 1000,
    localparam int PW        = $clog2(CLK_PER_US + 1),
    localparam int TW        = $clog2(MAX_US + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [TW-1:0] us_cnt
);

    logic [PW-1:0] pre_q;
    logic          tick;

    assign tick = (pre_q == PW'(CLK_PER_US - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q  <= '0;
            us_cnt <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick && us_cnt != TW'(MAX_US))
                us_cnt <= us_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hrst_line_watch.sv
module hrst_line_watch
    import hrst_pkg::*;
#(
    parameter int TW     = 16,
    parameter int DET_US = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] us_cnt,
    input  logic          act_n,
    input  logic          diag_n,
    output hrst_lines_t   lines
);

    logic win_open;
    assign win_open = (us_cnt < TW'(DET_US));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lines <= '0;
        end else if (en) begin
            if (win_open && !act_n)
                lines.found <= 1'b1;
            if (!diag_n)
                lines.diag_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/hrst_seq.sv
module hrst_seq
    import hrst_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int RST_US     = 25,
    parameter int BSY_CYC    = 40,
    parameter int DET_US     = 450000,
    parameter int DIAG_US    = 30000000,
    parameter int DONE_US    = 30500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       drv0_busy,
    input  logic       drv1_busy,
    input  logic       diag_ok_n,
    input  logic       drv_act_n,
    output logic       rst_line_n,
    output logic       active,
    output logic       reset_done,
    output logic       drv1_found,
    output logic [1:0] err_code
);

    localparam int MAX_US = max2(DONE_US, RST_US);
    localparam int TW     = $clog2(MAX_US + 1);
    localparam int BW     = $clog2(BSY_CYC + 1);

    hrst_state_e   state_q;
    hrst_err_e     err_q;
    logic          done_q;
    logic [BW-1:0] bcnt_q;
    logic [TW-1:0] us_cnt;
    hrst_lines_t   lines;
    logic          pulse_end;
    logic          tmr_clr;
    logic          win_closed;
    logic          finish_ok;
    logic          diag_late;

    assign pulse_end  = (state_q == ST_PULSE) && (us_cnt == TW'(RST_US));
    assign tmr_clr    = (state_q == ST_IDLE) || pulse_end;
    assign win_closed = (us_cnt >= TW'(DET_US));
    assign finish_ok  = !drv0_busy &&
                        (lines.found ? (lines.diag_seen && !drv1_busy) : win_closed);
    assign diag_late  = lines.found && !lines.diag_seen && (us_cnt >= TW'(DIAG_US));

    hrst_us_timer #(
        .CLK_PER_US(CLK_PER_US),
        .MAX_US    (MAX_US)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .us_cnt(us_cnt)
    );

    hrst_line_watch #(
        .TW    (TW),
        .DET_US(DET_US)
    ) u_lines (
        .clk   (clk),
        .rst   (rst),
        .clr   ((state_q == ST_IDLE) && start),
        .en    ((state_q == ST_WAITBSY) || (state_q == ST_WATCH)),
        .us_cnt(us_cnt),
        .act_n (drv_act_n),
        .diag_n(diag_ok_n),
        .lines (lines)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            done_q  <= 1'b0;
            bcnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q != ST_WAITBSY)
                bcnt_q <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_PULSE;
                        err_q   <= ERR_NONE;
                    end
                end
                ST_PULSE: begin
                    if (pulse_end)
                        state_q <= ST_WAITBSY;
                end
                ST_WAITBSY: begin
                    if (drv0_busy) begin
                        state_q <= ST_WATCH;
                    end else if (bcnt_q == BW'(BSY_CYC - 1)) begin
                        state_q <= ST_IDLE;
                        err_q   <= ERR_NO_BUSY;
                        done_q  <= 1'b1;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
                ST_WATCH: begin
                    if (finish_ok) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (diag_late) begin
                        state_q <= ST_IDLE;
                        err_q   <= ERR_DIAG;
                        done_q  <= 1'b1;
                    end else if (us_cnt >= TW'(DONE_US)) begin
                        state_q <= ST_IDLE;
                        err_q   <= ERR_LATE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rst_line_n = (state_q != ST_PULSE);
    assign active     = (state_q != ST_IDLE);
    assign reset_done = done_q;
    assign drv1_found = lines.found;
    assign err_code   = err_q;

endmodule

// File: rtl/hrst_seq_chk.sv
module hrst_seq_chk #(
    parameter int CLK_PER_US = 100,
    parameter int RST_US     = 25,
    parameter int DET_US     = 450000,
    parameter int DIAG_US    = 30000000,
    parameter int DONE_US    = 30500000
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       rst_line_n,
    input logic       active,
    input logic       reset_done,
    input logic       drv1_found,
    input logic [1:0] err_code
);

    localparam longint LOW_MIN  = longint'(RST_US) * CLK_PER_US;
    localparam longint DET_MIN  = longint'(DET_US) * CLK_PER_US;
    localparam longint DIAG_MIN = longint'(DIAG_US) * CLK_PER_US;
    localparam longint LATE_MIN = longint'(DONE_US) * CLK_PER_US;

    longint low_cnt;
    longint up_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= 0;
            up_cnt  <= 0;
        end else begin
            low_cnt <= rst_line_n ? 0 : low_cnt + 1;
            up_cnt  <= rst_line_n ? up_cnt + 1 : 0;
        end
    end

    assert_low_in_seq_R1: assert property (@(posedge clk) disable iff (rst)
        !rst_line_n |-> active);

    assert_low_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_line_n) |-> (low_cnt >= LOW_MIN));

    assert_found_after_release_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(drv1_found) |-> (rst_line_n && active));

    assert_diag_not_early_R5: assert property (@(posedge clk) disable iff (rst)
        (reset_done && err_code == 2'd2) |-> (up_cnt >= DIAG_MIN));

    assert_lone_not_early_R6: assert property (@(posedge clk) disable iff (rst)
        (reset_done && err_code == 2'd0 && !drv1_found) |-> (up_cnt >= DET_MIN));

    assert_late_not_early_R7: assert property (@(posedge clk) disable iff (rst)
        (reset_done && err_code == 2'd3) |-> (up_cnt >= LATE_MIN));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        reset_done |=> !reset_done);

    assert_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
        reset_done |-> (!active && rst_line_n));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!active && !start) |=> ($stable(err_code) && $stable(drv1_found)));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (active && rst_line_n) |=> rst_line_n);

endmodule

bind hrst_seq hrst_seq_chk #(
    .CLK_PER_US(CLK_PER_US),
    .RST_US    (RST_US),
    .DET_US    (DET_US),
    .DIAG_US   (DIAG_US),
    .DONE_US   (DONE_US)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rst_line_n(rst_line_n),
    .active    (active),
    .reset_done(reset_done),
    .drv1_found(drv1_found),
    .err_code  (err_code)
);

// File: tb/hrst_seq_test.sv
module hrst_seq_test;

    localparam int CPU  = 4;
    localparam int RSTU = 5;
    localparam int BSYC = 8;
    localparam int DETU = 20;
    localparam int DIAGU = 60;
    localparam int DONEU = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic drv0_busy = 1'b0;
    logic drv1_busy = 1'b0;
    logic diag_ok_n = 1'b1;
    logic drv_act_n = 1'b1;
    logic rst_line_n, active, reset_done, drv1_found;
    logic [1:0] err_code;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    hrst_seq #(
        .CLK_PER_US(CPU), .RST_US(RSTU), .BSY_CYC(BSYC),
        .DET_US(DETU), .DIAG_US(DIAGU), .DONE_US(DONEU)
    ) uut (
        .clk(clk), .rst(rst), .start(start),
        .drv0_busy(drv0_busy), .drv1_busy(drv1_busy),
        .diag_ok_n(diag_ok_n), .drv_act_n(drv_act_n),
        .rst_line_n(rst_line_n), .active(active), .reset_done(reset_done),
        .drv1_found(drv1_found), .err_code(err_code)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // One sequence. b0_clr: -2 never busy, -1 busy forever, else cycle busy clears.
    task automatic run_seq(input int b0_clr, input int b1_on, input int b1_clr,
                           input int da_from, input int da_to, input int pd_at,
                           input int st_at, output int elapsed, output int lowc,
                           output int ign_bad);
        int n;
        ign_bad = 0;
        drv0_busy = (b0_clr != -2);
        drv1_busy = b1_on[0];
        drv_act_n = 1'b1;
        diag_ok_n = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 line low after start", int'(rst_line_n), 0);
        check("R1 active after start", int'(active), 1);
        lowc = 0;
        while (!rst_line_n && lowc < 1000) begin
            lowc++;
            @(negedge clk);
        end
        n = 0;
        forever begin
            drv0_busy = (b0_clr == -1) ? 1'b1 : (b0_clr == -2) ? 1'b0 : (n < b0_clr);
            drv1_busy = b1_on[0] && (b1_clr < 0 || n < b1_clr);
            drv_act_n = !(n >= da_from && n < da_to);
            diag_ok_n = !(pd_at >= 0 && n >= pd_at);
            start     = (n == st_at);
            if (st_at >= 0 && n > st_at && n <= st_at + 4 && (!rst_line_n || !active))
                ign_bad++;
            @(negedge clk);
            n++;
            if (reset_done || n > 2000) break;
        end
        start = 1'b0;
        elapsed = n;
        check("R8 active low with done", int'(active), 0);
        @(negedge clk);
        check("R8 done lasts one cycle", int'(reset_done), 0);
    endtask

    task automatic t_reset_state;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 line high in reset", int'(rst_line_n), 1);
        check("R10 idle in reset", int'(active), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 done low", int'(reset_done), 0);
        check("R10 err zero", int'(err_code), 0);
        check("R10 found low", int'(drv1_found), 0);
        check("R10 line high after", int'(rst_line_n), 1);
    endtask

    task automatic t_single_drive;
        int el, lw, ib;
        run_seq(10, 0, -1, 1000, 1000, -1, -1, el, lw, ib);
        check_rng("R2 low width", lw, RSTU*CPU, RSTU*CPU + 1);
        check("R6 lone err", int'(err_code), 0);
        check("R4 lone not found", int'(drv1_found), 0);
        check_rng("R6 lone waits window", el, DETU*CPU, DETU*CPU + 4);
        repeat (3) @(negedge clk);
        check("R8 err holds", int'(err_code), 0);
        check("R8 stays idle", int'(active), 0);
    endtask

    task automatic t_two_drives;
        int el, lw, ib;
        run_seq(120, 1, 100, 20, 30, 100, -1, el, lw, ib);
        check("R4 found", int'(drv1_found), 1);
        check("R6 pair err", int'(err_code), 0);
        check_rng("R6 pair done time", el, 120, 124);
        repeat (3) @(negedge clk);
        check("R8 found holds", int'(drv1_found), 1);
    endtask

    task automatic t_late_active;
        int el, lw, ib;
        run_seq(110, 0, -1, 90, 100, -1, -1, el, lw, ib);
        check("R4 late active ignored", int'(drv1_found), 0);
        check_rng("R6 done after busy", el, 110, 114);
        check("R6 late err", int'(err_code), 0);
    endtask

    task automatic t_no_busy;
        int el, lw, ib;
        run_seq(-2, 0, -1, 1000, 1000, -1, -1, el, lw, ib);
        check("R3 err code", int'(err_code), 1);
        check_rng("R3 window", el, BSYC, BSYC + 2);
    endtask

    task automatic t_diag_timeout;
        int el, lw, ib;
        run_seq(-1, 1, -1, 10, 40, -1, -1, el, lw, ib);
        check("R5 err code", int'(err_code), 2);
        check_rng("R5 time", el, DIAGU*CPU, DIAGU*CPU + 4);
        check("R5 found", int'(drv1_found), 1);
    endtask

    task automatic t_late_finish;
        int el, lw, ib;
        run_seq(-1, 0, -1, 1000, 1000, -1, -1, el, lw, ib);
        check("R7 err code", int'(err_code), 3);
        check_rng("R7 time", el, DONEU*CPU, DONEU*CPU + 4);
    endtask

    task automatic t_start_ignored;
        int el, lw, ib;
        run_seq(10, 0, -1, 1000, 1000, -1, 30, el, lw, ib);
        check("R9 no second pulse", ib, 0);
        check("R9 err", int'(err_code), 0);
        check_rng("R9 timing unchanged", el, DETU*CPU, DETU*CPU + 4);
        repeat (2) @(negedge clk);
        check("R9 idle after", int'(active), 0);
    endtask

    initial begin
        t_reset_state();
        t_single_drive();
        t_two_drives();
        t_late_active();
        t_no_busy();
        t_diag_timeout();
        t_late_finish();
        t_start_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule